// File: doc/BRIEF.md
# Two-Dimensional Bit-Error Eye-Scan Sequencer

This block measures how the bit-error rate of a receive lane varies with the
sampling position. It walks a grid of sampler settings: one axis is the
sampling delay (time), the other is the 0/1 decision threshold (amplitude). At
every grid point it drives the two control codes to the sampler and waits a
programmable settle time. It then counts the errored bits among a fixed number
of valid received bits, and writes the error count for that point to a result
port. The bit-error rate of a point is that count divided by the window size,
which is one million bits by default.

Four receive lanes share one sequencer. A lane-select value is captured when
the scan starts, and only that lane's per-bit valid and error strobes are used
until the scan ends. A start pulse launches the scan. The block writes one
result per grid point in raster order and raises a done flag after the final
point. Software or a downstream memory turns the results into an eye map.

Top module: `eye_scan_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, busy_o, done_o and wr_en_o are 0 and both control codes are 0.
- R2: One scan writes exactly X_STEPS*Y_STEPS results. The delay index advances fastest and the threshold index advances when the delay index wraps. The first write is (0,0) and the last write is (X_STEPS-1, Y_STEPS-1).
- R3: delay_code_o and thresh_code_o equal the delay and threshold indices of the point being measured. They stay constant for the whole settle and count time of that point.
- R4: After start, and after each result write that is not the last, the block spends settle_i+1 cycles settling. The settle_i value is captured at start. Bits presented while settling are not counted.
- R5: A point's window closes on the cycle in which its BITS_PER_POINT-th valid bit is seen on the selected lane. Cycles in which that lane's valid strobe is 0 add nothing.
- R6: In the cycle after a window closes, wr_en_o is high for exactly one cycle. In that cycle wr_x_o and wr_y_o carry the point indices and wr_count_o carries the number of window bits whose error strobe was 1.
- R7: lane_sel_i, captured at start, picks bit lane_sel_i of bit_valid_i and bit_err_i. Strobes on the other lanes have no effect on any result.
- R8: busy_o is high from the cycle after an accepted start through the last result write. done_o rises in the cycle after the last write and stays high until the next accepted start. done_o and busy_o are never both high.
- R9: A start pulse while busy_o is high is ignored. It does not restart the scan, and the lane and settle values it carries are not captured.
- R10: The error count saturates at BITS_PER_POINT and never exceeds it. With every window bit in error, wr_count_o equals BITS_PER_POINT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that starts a scan when idle |
| lane_sel_i | input | LSEL_W | Lane to scan, captured at start |
| settle_i | input | SETTLE_W | Settle cycles minus one, captured at start |
| bit_valid_i | input | LANES | Per-lane strobe: a received bit was compared this cycle |
| bit_err_i | input | LANES | Per-lane strobe: that bit differed from the reference |
| delay_code_o | output | XW | Sampling delay code to the receiver |
| thresh_code_o | output | YW | Decision threshold code to the receiver |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | Last scan completed |
| wr_en_o | output | 1 | Result write strobe |
| wr_x_o | output | XW | Delay index of the written result |
| wr_y_o | output | YW | Threshold index of the written result |
| wr_count_o | output | CNT_W | Error count of the written result |

## Verification
Each scan is checked against a behavioural model on every clock, using a small grid and a short window. Error strobes at random with every bit valid test the counting and write timing. Sparse valid strobes show that cycles without valid do not advance the window. Errors that appear only on unselected lanes must give all-zero counts, which exposes a wrong lane pick. Every bit in error must give counts equal to the window size, which tests saturation. Scans with zero and non-zero settle values tell settle-length faults apart from window-length faults. A stray start in mid-scan that carries a different lane and settle value tests that start is ignored while busy.

// File: rtl/eye_scan_pkg.sv
// Shared types for the eye-scan sequencer.
package eye_scan_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_COUNT  = 2'd2,
        ST_WRITE  = 2'd3
    } scan_state_e;
endpackage

// File: rtl/eye_lane_pick.sv
// Selects one lane's valid and error strobes from the per-lane vectors.
// Assumes sel_i is below LANES; the output is purely combinational.
module eye_lane_pick #(
    parameter int LANES  = 4,
    parameter int LSEL_W = 2
) (
    input  logic [LSEL_W-1:0] sel_i,
    input  logic [LANES-1:0]  valid_i,
    input  logic [LANES-1:0]  err_i,
    output logic              valid_o,
    output logic              err_o
);
    logic [LANES-1:0] hit;

    // One-hot decode of the selected lane, one term per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_dec
        assign hit[g] = (sel_i == LSEL_W'(g));
    end

    // AND-OR reduction of the strobes through the decode.
    assign valid_o = |(hit & valid_i);
    assign err_o   = |(hit & err_i);
endmodule

// File: rtl/eye_grid_walk.sv
// Raster walker over the scan grid: x advances fastest, y steps when x wraps.
// Both indices return to zero after the last point. Assumes X_STEPS, Y_STEPS >= 2.
module eye_grid_walk #(
    parameter int X_STEPS = 8,
    parameter int Y_STEPS = 8,
    parameter int XW      = $clog2(X_STEPS),
    parameter int YW      = $clog2(Y_STEPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          step_i,
    output logic [XW-1:0] x_o,
    output logic [YW-1:0] y_o,
    output logic          last_o
);
    localparam logic [XW-1:0] XMAX = XW'(X_STEPS - 1);
    localparam logic [YW-1:0] YMAX = YW'(Y_STEPS - 1);

    // Index registers: cleared on reset or scan start, advanced per point.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            x_o <= '0;
            y_o <= '0;
        end else if (step_i) begin
            if (x_o == XMAX) begin
                x_o <= '0;
                y_o <= (y_o == YMAX) ? '0 : y_o + 1'b1;
            end else begin
                x_o <= x_o + 1'b1;
            end
        end
    end

    // Flags the final grid point.
    assign last_o = (x_o == XMAX) && (y_o == YMAX);
endmodule

// File: rtl/eye_window_count.sv
// Counts valid bits and errored bits over a window of BITS_PER_POINT bits.
// The error count saturates at the window size. last_o marks the cycle in which
// the final window bit is accepted. Assumes BITS_PER_POINT >= 2.
module eye_window_count #(
    parameter int BITS_PER_POINT = 1000000,
    parameter int CNT_W          = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             en_i,
    input  logic             valid_i,
    input  logic             err_i,
    output logic [CNT_W-1:0] err_cnt_o,
    output logic             last_o
);
    localparam int BW = $clog2(BITS_PER_POINT);
    localparam logic [BW-1:0]    BIT_LAST = BW'(BITS_PER_POINT - 1);
    localparam logic [CNT_W-1:0] ERR_CAP  = CNT_W'(BITS_PER_POINT);

    logic [BW-1:0] bit_cnt;
    logic          take;

    assign take   = en_i && valid_i;
    assign last_o = take && (bit_cnt == BIT_LAST);

    // Bit and error counters: cleared while settling, advanced on accepted bits.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            bit_cnt   <= '0;
            err_cnt_o <= '0;
        end else if (take) begin
            bit_cnt <= last_o ? '0 : bit_cnt + 1'b1;
            if (err_i && (err_cnt_o != ERR_CAP)) begin
                err_cnt_o <= err_cnt_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/eye_scan_seq.sv
// Eye-scan sequencer top: steps the sampler over a delay/threshold grid. At each
// point it settles, counts errors over a fixed bit window and writes one result.
// Lane and settle values are captured at start. Start is ignored while busy.
module eye_scan_seq
    import eye_scan_pkg::*;
#(
    parameter int X_STEPS        = 8,
    parameter int Y_STEPS        = 8,
    parameter int BITS_PER_POINT = 1000000,
    parameter int CNT_W          = 20,
    parameter int SETTLE_W       = 8,
    parameter int LANES          = 4,
    parameter int XW             = $clog2(X_STEPS),
    parameter int YW             = $clog2(Y_STEPS),
    parameter int LSEL_W         = $clog2(LANES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [LSEL_W-1:0]   lane_sel_i,
    input  logic [SETTLE_W-1:0] settle_i,
    input  logic [LANES-1:0]    bit_valid_i,
    input  logic [LANES-1:0]    bit_err_i,
    output logic [XW-1:0]       delay_code_o,
    output logic [YW-1:0]       thresh_code_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                wr_en_o,
    output logic [XW-1:0]       wr_x_o,
    output logic [YW-1:0]       wr_y_o,
    output logic [CNT_W-1:0]    wr_count_o
);
    scan_state_e         state;
    logic [SETTLE_W-1:0] settle_cnt;
    logic [SETTLE_W-1:0] settle_q;
    logic [LSEL_W-1:0]   lane_q;
    logic                done_q;
    logic                accept;
    logic                lane_valid;
    logic                lane_err;
    logic                grid_last;
    logic                win_last;
    logic [XW-1:0]       gx;
    logic [YW-1:0]       gy;
    logic [CNT_W-1:0]    err_cnt;

    assign accept = (state == ST_IDLE) && start_i;

    eye_lane_pick #(.LANES(LANES), .LSEL_W(LSEL_W)) u_pick (
        .sel_i   (lane_q),
        .valid_i (bit_valid_i),
        .err_i   (bit_err_i),
        .valid_o (lane_valid),
        .err_o   (lane_err)
    );

    eye_grid_walk #(.X_STEPS(X_STEPS), .Y_STEPS(Y_STEPS), .XW(XW), .YW(YW)) u_grid (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .step_i  (state == ST_WRITE),
        .x_o     (gx),
        .y_o     (gy),
        .last_o  (grid_last)
    );

    eye_window_count #(.BITS_PER_POINT(BITS_PER_POINT), .CNT_W(CNT_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (state == ST_SETTLE),
        .en_i      (state == ST_COUNT),
        .valid_i   (lane_valid),
        .err_i     (lane_err),
        .err_cnt_o (err_cnt),
        .last_o    (win_last)
    );

    // Scan sequencing: idle -> settle -> count -> write, repeated per point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            settle_cnt <= '0;
            settle_q   <= '0;
            lane_q     <= '0;
            done_q     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        lane_q     <= lane_sel_i;
                        settle_q   <= settle_i;
                        settle_cnt <= '0;
                        done_q     <= 1'b0;
                        state      <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (settle_cnt == settle_q) begin
                        state <= ST_COUNT;
                    end else begin
                        settle_cnt <= settle_cnt + 1'b1;
                    end
                end
                ST_COUNT: begin
                    if (win_last) begin
                        state <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    settle_cnt <= '0;
                    if (grid_last) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        state <= ST_SETTLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output mapping of the current point, status and result port.
    assign delay_code_o  = gx;
    assign thresh_code_o = gy;
    assign busy_o        = (state != ST_IDLE);
    assign done_o        = done_q;
    assign wr_en_o       = (state == ST_WRITE);
    assign wr_x_o        = gx;
    assign wr_y_o        = gy;
    assign wr_count_o    = err_cnt;
endmodule

// File: rtl/eye_scan_seq_chk.sv
// Temporal checks on the eye-scan sequencer ports, attached by bind.
// Assumes the same parameters as the bound instance.
module eye_scan_seq_chk #(
    parameter int X_STEPS        = 8,
    parameter int Y_STEPS        = 8,
    parameter int BITS_PER_POINT = 1000000,
    parameter int CNT_W          = 20,
    parameter int XW             = 3,
    parameter int YW             = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             wr_en_o,
    input logic [XW-1:0]    wr_x_o,
    input logic [YW-1:0]    wr_y_o,
    input logic [CNT_W-1:0] wr_count_o,
    input logic [XW-1:0]    delay_code_o,
    input logic [YW-1:0]    thresh_code_o
);
    p_wr_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);

    p_codes_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !wr_en_o) |=>
            (!busy_o || ($stable(delay_code_o) && $stable(thresh_code_o))));

    p_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));

    p_last_point_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(wr_en_o) && ($past(wr_x_o) == XW'(X_STEPS - 1))
                           && ($past(wr_y_o) == YW'(Y_STEPS - 1))));

    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !wr_en_o) |=> busy_o);

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_count_o <= CNT_W'(BITS_PER_POINT)));
endmodule

bind eye_scan_seq eye_scan_seq_chk #(
    .X_STEPS(X_STEPS), .Y_STEPS(Y_STEPS), .BITS_PER_POINT(BITS_PER_POINT),
    .CNT_W(CNT_W), .XW(XW), .YW(YW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .wr_en_o(wr_en_o), .wr_x_o(wr_x_o), .wr_y_o(wr_y_o),
    .wr_count_o(wr_count_o), .delay_code_o(delay_code_o),
    .thresh_code_o(thresh_code_o)
);

// File: tb/eye_scan_seq_tb.sv
module eye_scan_seq_tb;
    localparam int X  = 4;
    localparam int Y  = 3;
    localparam int NB = 16;
    localparam int CW = 20;
    localparam int SW = 4;
    localparam int LN = 4;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          start_i = 0;
    logic [1:0]    lane_sel_i = 0;
    logic [SW-1:0] settle_i = 0;
    logic [LN-1:0] bit_valid_i = 0;
    logic [LN-1:0] bit_err_i = 0;
    logic [1:0]    delay_code_o;
    logic [1:0]    thresh_code_o;
    logic          busy_o, done_o, wr_en_o;
    logic [1:0]    wr_x_o;
    logic [1:0]    wr_y_o;
    logic [CW-1:0] wr_count_o;

    int tests = 0;
    int fails = 0;
    int mode  = 0;
    int widx  = 0;

    always #10 clk = ~clk;

    eye_scan_seq #(.X_STEPS(X), .Y_STEPS(Y), .BITS_PER_POINT(NB), .CNT_W(CW),
                   .SETTLE_W(SW), .LANES(LN)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .lane_sel_i(lane_sel_i),
        .settle_i(settle_i), .bit_valid_i(bit_valid_i), .bit_err_i(bit_err_i),
        .delay_code_o(delay_code_o), .thresh_code_o(thresh_code_o),
        .busy_o(busy_o), .done_o(done_o), .wr_en_o(wr_en_o), .wr_x_o(wr_x_o),
        .wr_y_o(wr_y_o), .wr_count_o(wr_count_o)
    );

    // Behavioural reference: phase 0 idle, 1 settle, 2 count, 3 write.
    int m_ph, m_x, m_y, m_sc, m_set, m_lane, m_bits, m_err;
    bit m_done;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_x = 0; m_y = 0; m_sc = 0; m_set = 0; m_lane = 0;
            m_bits = 0; m_err = 0; m_done = 0;
        end else begin
            case (m_ph)
                0: if (start_i) begin
                    m_lane = lane_sel_i; m_set = settle_i; m_sc = 0;
                    m_done = 0; m_x = 0; m_y = 0; m_ph = 1;
                end
                1: begin
                    m_bits = 0; m_err = 0;
                    if (m_sc == m_set) m_ph = 2; else m_sc++;
                end
                2: if (bit_valid_i[m_lane]) begin
                    m_bits++;
                    if (bit_err_i[m_lane] && m_err < NB) m_err++;
                    if (m_bits == NB) begin m_bits = 0; m_ph = 3; end
                end
                default: begin
                    m_sc = 0;
                    if (m_x == X - 1 && m_y == Y - 1) begin
                        m_x = 0; m_y = 0; m_done = 1; m_ph = 0;
                    end else begin
                        if (m_x == X - 1) begin m_x = 0; m_y++; end
                        else m_x++;
                        m_ph = 1;
                    end
                end
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, taken at the falling edge.
    task automatic compare();
        chk(delay_code_o == m_x, "R3 delay code", delay_code_o, m_x);
        chk(thresh_code_o == m_y, "R3 threshold code", thresh_code_o, m_y);
        chk(wr_en_o == (m_ph == 3), "R4 R5 write timing", wr_en_o, m_ph == 3);
        chk(busy_o == (m_ph != 0), "R8 busy", busy_o, m_ph != 0);
        chk(done_o == m_done, "R8 done", done_o, m_done);
        if (wr_en_o) begin
            chk(wr_count_o == m_err, "R6 error count", wr_count_o, m_err);
            chk(wr_x_o == widx % X, "R2 raster x", wr_x_o, widx % X);
            chk(wr_y_o == widx / X, "R2 raster y", wr_y_o, widx / X);
            if (mode == 1) chk(wr_count_o == 0, "R7 other lanes ignored", wr_count_o, 0);
            if (mode == 2) chk(wr_count_o == NB, "R10 saturated count", wr_count_o, NB);
            widx++;
        end
    endtask

    // Drive the lane strobes for the current pattern.
    task automatic drive();
        case (mode)
            0: begin bit_valid_i = '1; bit_err_i = LN'($urandom); end
            1: begin bit_valid_i = '1; bit_err_i = ~(LN'(1) << lane_sel_i); end
            2: begin bit_valid_i = '1; bit_err_i = '1; end
            default: begin
                bit_valid_i = LN'($urandom) & LN'($urandom);
                bit_err_i   = LN'($urandom);
            end
        endcase
    endtask

    task automatic run_scan(input int lane, input int st, input int md, input bit stray);
        int cyc = 0;
        @(negedge clk);
        compare();
        mode = md; lane_sel_i = 2'(lane); settle_i = SW'(st);
        start_i = 1; widx = 0;
        drive();
        @(negedge clk);
        compare();
        start_i = 0;
        drive();
        while (!done_o && cyc < 5000) begin
            @(negedge clk);
            compare();
            start_i = 0;
            if (stray && cyc == 30) begin
                start_i = 1;
                lane_sel_i = 2'(lane + 1);
                settle_i = SW'(st + 3);
            end
            drive();
            cyc++;
        end
        chk(widx == X * Y, "R2 write count", widx, X * Y);
        chk(done_o == 1, "R8 done after scan", done_o, 1);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && wr_en_o == 0, "R1 reset status",
            {busy_o, done_o, wr_en_o}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(delay_code_o == 0 && thresh_code_o == 0, "R1 reset codes",
            {delay_code_o, thresh_code_o}, 0);
        chk(busy_o == 0 && done_o == 0, "R1 idle after reset", {busy_o, done_o}, 0);
        run_scan(0, 2, 0, 0);  // random errors, R4 settle 3
        run_scan(2, 0, 1, 0);  // R7 errors only on other lanes, zero settle
        run_scan(3, 5, 2, 1);  // R10 all errors, R9 stray start
        run_scan(1, 1, 3, 0);  // R5 sparse valid
        run_scan(2, 0, 0, 1);  // R9 stray start with random errors
        repeat (3) begin
            @(negedge clk);
            compare();
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule